// File: doc/BRIEF.md
# Low-Power Mode and Clock-Gating Controller

This block decides which clocks of a small microcontroller core are running. Software programs it through two byte-wide registers on a simple register bus. One register holds the mode requests: stop, sleep, pin hold, software reset and the CPU throttle level. The other holds the clock settings: main-or-PLL source, PLL multiplier and wake-up wait length, plus a read-only status bit that shows which source is in use.

The block produces clock enables for the CPU, the peripherals and the time-base timer. It also drives the oscillator enable, the PLL enable and the multiplier code. When the core leaves stop or hardware standby, it counts the oscillator settling time. It can stretch the CPU clock after each access. Seven operating modes are supported: PLL run, PLL sleep, main run, main sleep, watch, stop and hardware standby. A settling-wait phase comes between the oscillator-off modes and run. The oscillator, the VCO and the real clock multiplexer sit outside this block and appear here only as enables and a lock status.

The `clk` input runs at the main oscillator rate. While the main clock is the source, the gated enables pulse on alternate cycles, which gives half the oscillator rate. While the PLL is the source, the enables are held high and the external multiplexer supplies the faster clock.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, the register at address 0 reads 0x10 and the register at address 1 reads 0xFC. `mode` is 2 (main run), `osc_en` is 1, and `pll_en` and `sys_rst_pulse` are 0.
- R2: Address 0 read format: bits 7, 6, 3 and 0 read 0, and bit 4 reads 1. Bit 5 (pin hold) and bits 2:1 (throttle code) read back what was written. Address 1 read format: bits 7 and 3 read 1, and bit 6 is the source status (1 = main clock). Bits 5:4 (wait code), bit 2 (source select, 1 = main) and bits 1:0 (multiplier code) read back what was written.
- R3: In main run, the CPU, peripheral and timer enables are equal to each other and toggle every cycle, and `pll_en` is 0.
- R4: Writing 0 to source-select bit 2 raises `pll_en` at once. The status bit and `mode` keep showing main until `pll_lock` is seen high. From the next cycle, `mode` is 0 (PLL run) and the enables are high every cycle. On leaving watch, stop or standby, the status returns to main, and the PLL must lock again.
- R5: Writing 1 to bit 6 alone of address 0 while running enters sleep: `mode` becomes 1 (PLL source) or 3 (main source). In sleep, `cpu_clk_en` is 0, the peripheral and timer enables behave as in run, and the oscillator stays on.
- R6: Writing 1 to bits 7 and 6 together enters watch (`mode` 4). In watch, only `tbt_clk_en` runs, at half rate, `osc_en` is 1 and `pll_en` is 0.
- R7: Writing 1 to bit 7 alone enters stop (`mode` 5). In stop, every clock enable, `osc_en` and `pll_en` are 0.
- R8: An interrupt in stop enters the settling wait (`mode` 7) with `osc_en` at 1. The wait lasts exactly 2^E cycles, where E is the exponent picked by the wait code (codes 0 to 3 select parameters `WAIT_EXP0` to `WAIT_EXP3`). After the wait, the block goes to run.
- R9: An interrupt in sleep or watch returns to run on the next cycle. In run, an interrupt has no effect. A sleep or stop request written in the same cycle as a pending interrupt is dropped, and the block stays in run.
- R10: `hw_stby` high enters standby (`mode` 6) from any mode on the next cycle, with everything off. When the pin drops, the settling wait for the current wait code follows, and then run.
- R11: In run, with throttle code c (c = 1, 2 or 3), a `cpu_access` pulse holds `cpu_clk_en` low for `PAUSE_UNIT`·2^(c−1) cycles. Code 0 gives no pause, and `per_clk_en` is not affected. An access that arrives during a pause is ignored.
- R12: Writing address 0 with bit 4 at 0 raises `sys_rst_pulse` for exactly the cycle after the write. Writing bit 4 as 1 gives no pulse.
- R13: `pll_mult` always equals the multiplier code (00 to 11 select ×1 to ×4).
- R14: `pins_hiz` is high only when the pin-hold bit is 1 and the mode is watch, stop or standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator rate clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby request pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode control, 1 clock select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_wake | input | 1 | An enabled interrupt is pending |
| cpu_access | input | 1 | CPU bus or memory access strobe |
| pll_lock | input | 1 | PLL locked status |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | 2 | PLL multiplier code |
| pll_src | output | 1 | Gated clocks are taken from the PLL |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| tbt_clk_en | output | 1 | Time-base timer clock enable |
| sys_rst_pulse | output | 1 | One-cycle software reset |
| pins_hiz | output | 1 | Put the output pins in high impedance |
| mode | output | 3 | Current mode code (0 to 7) |

## Verification
The case that needs the most care is a pending interrupt that arrives in the same cycle as a sleep or stop request. The bench raises `irq_wake` and performs the register write on the same clock edge. It passes only if `mode` stays at run in the following cycle. A second overlap is the end of a pause window against a new access. The bench sweeps every throttle code, counts the cycles during which `cpu_clk_en` is held low while `per_clk_en` stays high, and compares that count with the computed pause length. It also sweeps every wait code, where the length of the settling phase is compared with 2^E.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_WATCH = 3'd2,
        ST_STOP  = 3'd3,
        ST_STBY  = 3'd4,
        ST_WAKE  = 3'd5
    } pcc_state_e;

    localparam logic ADDR_LPM = 1'b0;
    localparam logic ADDR_CKS = 1'b1;

    // mode control register bit positions
    localparam int LPM_STOP  = 7;
    localparam int LPM_SLEEP = 6;
    localparam int LPM_HIZ   = 5;
    localparam int LPM_SWRST = 4;
    localparam int LPM_CG_LO = 1;

    // clock select register bit positions
    localparam int CKS_STAT  = 6;
    localparam int CKS_WS_LO = 4;
    localparam int CKS_SEL   = 2;
    localparam int CKS_MU_LO = 0;

    localparam logic [2:0] MODE_PLL_RUN   = 3'd0;
    localparam logic [2:0] MODE_PLL_SLEEP = 3'd1;
    localparam logic [2:0] MODE_MAIN_RUN  = 3'd2;
    localparam logic [2:0] MODE_MAIN_SLP  = 3'd3;
    localparam logic [2:0] MODE_WATCH     = 3'd4;
    localparam logic [2:0] MODE_STOP      = 3'd5;
    localparam logic [2:0] MODE_STBY      = 3'd6;
    localparam logic [2:0] MODE_WAKE      = 3'd7;

endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       addr,
    input  logic [7:0] wdata,
    input  logic       mcm,
    output logic       spl,
    output logic [1:0] cg,
    output logic [1:0] ws,
    output logic       sel_main,
    output logic [1:0] mult,
    output logic       stop_req,
    output logic       sleep_req,
    output logic       swrst,
    output logic [7:0] rdata
);

    typedef struct packed {
        logic       spl;
        logic [1:0] cg;
        logic [1:0] ws;
        logic       sel;
        logic [1:0] mult;
        logic       swrst;
    } regs_t;

    localparam regs_t REGS_RST = '{spl: 1'b0, cg: 2'b00, ws: 2'b11,
                                   sel: 1'b1, mult: 2'b00, swrst: 1'b0};

    regs_t r_d, r_q;
    logic  wr_lpm, wr_cks;
    logic  unused_wdata;

    assign unused_wdata = wdata[3];

    always_comb begin
        wr_lpm   = wr && (addr == ADDR_LPM);
        wr_cks   = wr && (addr == ADDR_CKS);
        r_d      = r_q;
        r_d.swrst = 1'b0;
        if (wr_lpm) begin
            r_d.spl   = wdata[LPM_HIZ];
            r_d.cg    = wdata[LPM_CG_LO +: 2];
            r_d.swrst = !wdata[LPM_SWRST];
        end
        if (wr_cks) begin
            r_d.ws   = wdata[CKS_WS_LO +: 2];
            r_d.sel  = wdata[CKS_SEL];
            r_d.mult = wdata[CKS_MU_LO +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign stop_req  = wr_lpm && wdata[LPM_STOP];
    assign sleep_req = wr_lpm && wdata[LPM_SLEEP];
    assign spl       = r_q.spl;
    assign cg        = r_q.cg;
    assign ws        = r_q.ws;
    assign sel_main  = r_q.sel;
    assign mult      = r_q.mult;
    assign swrst     = r_q.swrst;

    always_comb begin
        if (addr == ADDR_LPM)
            rdata = {2'b00, r_q.spl, 1'b1, 1'b0, r_q.cg, 1'b0};
        else
            rdata = {1'b1, mcm, r_q.ws, 1'b1, r_q.sel, r_q.mult};
    end

    AST_SWRST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |-> $past(wr && (addr == ADDR_LPM) && !wdata[LPM_SWRST])); // R12

endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
    import pcc_pkg::*;
#(
    parameter int WAIT_EXP0 = 2,
    parameter int WAIT_EXP1 = 12,
    parameter int WAIT_EXP2 = 13,
    parameter int WAIT_EXP3 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_stby,
    input  logic       irq,
    input  logic       stop_req,
    input  logic       sleep_req,
    input  logic       sel_main,
    input  logic [1:0] ws,
    input  logic       pll_lock,
    output pcc_state_e state,
    output logic       mcm,
    output logic       ph
);

    localparam int MAX01 = (WAIT_EXP0 > WAIT_EXP1) ? WAIT_EXP0 : WAIT_EXP1;
    localparam int MAX23 = (WAIT_EXP2 > WAIT_EXP3) ? WAIT_EXP2 : WAIT_EXP3;
    localparam int MAXE  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CW    = (MAXE < 1) ? 1 : MAXE;

    typedef struct packed {
        pcc_state_e    st;
        logic [CW-1:0] cnt;
        logic          mcm;
        logic          ph;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [CW-1:0] wait_m1(input logic [1:0] code);
        int e;
        case (code)
            2'd0:    e = WAIT_EXP0;
            2'd1:    e = WAIT_EXP1;
            2'd2:    e = WAIT_EXP2;
            default: e = WAIT_EXP3;
        endcase
        return CW'((32'd1 << e) - 32'd1);
    endfunction

    always_comb begin
        s_d    = s_q;
        s_d.ph = !s_q.ph;
        case (s_q.st)
            ST_RUN: begin
                if (!irq) begin
                    if (stop_req && sleep_req) s_d.st = ST_WATCH;
                    else if (stop_req)         s_d.st = ST_STOP;
                    else if (sleep_req)        s_d.st = ST_SLEEP;
                end
            end
            ST_SLEEP, ST_WATCH: if (irq) s_d.st = ST_RUN;
            ST_STOP:            if (irq) s_d.st = ST_WAKE;
            ST_STBY:            s_d.st = ST_WAKE;
            ST_WAKE: begin
                if (s_q.cnt == '0) s_d.st  = ST_RUN;
                else               s_d.cnt = s_q.cnt - CW'(1);
            end
            default: s_d.st = ST_RUN;
        endcase
        if (hw_stby) s_d.st = ST_STBY;
        if (s_d.st == ST_WAKE && s_q.st != ST_WAKE) s_d.cnt = wait_m1(ws);

        if (s_q.st != ST_RUN && s_q.st != ST_SLEEP) s_d.mcm = 1'b1;
        else if (sel_main)                          s_d.mcm = 1'b1;
        else if (pll_lock)                          s_d.mcm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN, cnt: '0, mcm: 1'b1, ph: 1'b0};
        else        s_q <= s_d;
    end

    assign state = s_q.st;
    assign mcm   = s_q.mcm;
    assign ph    = s_q.ph;

    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (s_q.st == ST_STBY)); // R10
    AST_WAKE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STOP && irq && !hw_stby) |=> (s_q.st == ST_WAKE)); // R8
    AST_WAKE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAKE && s_q.cnt == '0 && !hw_stby) |=> (s_q.st == ST_RUN)); // R8
    AST_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_SLEEP || s_q.st == ST_WATCH) && irq && !hw_stby) |=> (s_q.st == ST_RUN)); // R9
    AST_PLL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.mcm) |-> $past(pll_lock)); // R4

endmodule

// File: rtl/pcc_throttle.sv
module pcc_throttle #(
    parameter int PAUSE_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access,
    input  logic       run,
    input  logic [1:0] code,
    output logic       pausing
);

    localparam int PMAX = 4 * PAUSE_UNIT;
    localparam int PW   = $clog2(PMAX + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } thr_t;

    thr_t t_d, t_q;

    function automatic logic [PW-1:0] pause_len(input logic [1:0] c);
        if (c == 2'd0) return '0;
        return PW'(PAUSE_UNIT << (int'(c) - 1));
    endfunction

    always_comb begin
        t_d = t_q;
        if (t_q.cnt != '0)          t_d.cnt = t_q.cnt - PW'(1);
        else if (access && run)     t_d.cnt = pause_len(code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{cnt: '0};
        else        t_q <= t_d;
    end

    assign pausing = (t_q.cnt != '0);

    AST_PAUSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.cnt != '0) |=> (t_q.cnt == $past(t_q.cnt) - PW'(1))); // R11

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int WAIT_EXP0  = 2,
    parameter int WAIT_EXP1  = 12,
    parameter int WAIT_EXP2  = 13,
    parameter int WAIT_EXP3  = 15,
    parameter int PAUSE_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_stby,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_wake,
    input  logic       cpu_access,
    input  logic       pll_lock,
    output logic       osc_en,
    output logic       pll_en,
    output logic [1:0] pll_mult,
    output logic       pll_src,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       tbt_clk_en,
    output logic       sys_rst_pulse,
    output logic       pins_hiz,
    output logic [2:0] mode
);

    logic       spl, sel_main, stop_req, sleep_req, mcm, ph, pausing, tick;
    logic [1:0] cg, ws;
    pcc_state_e state;

    pcc_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .mcm      (mcm),
        .spl      (spl),
        .cg       (cg),
        .ws       (ws),
        .sel_main (sel_main),
        .mult     (pll_mult),
        .stop_req (stop_req),
        .sleep_req(sleep_req),
        .swrst    (sys_rst_pulse),
        .rdata    (reg_rdata)
    );

    pcc_seq #(
        .WAIT_EXP0(WAIT_EXP0),
        .WAIT_EXP1(WAIT_EXP1),
        .WAIT_EXP2(WAIT_EXP2),
        .WAIT_EXP3(WAIT_EXP3)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_stby  (hw_stby),
        .irq      (irq_wake),
        .stop_req (stop_req),
        .sleep_req(sleep_req),
        .sel_main (sel_main),
        .ws       (ws),
        .pll_lock (pll_lock),
        .state    (state),
        .mcm      (mcm),
        .ph       (ph)
    );

    pcc_throttle #(.PAUSE_UNIT(PAUSE_UNIT)) i_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (cpu_access),
        .run    (state == ST_RUN),
        .code   (cg),
        .pausing(pausing)
    );

    always_comb begin
        tick       = mcm ? ph : 1'b1;
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        tbt_clk_en = 1'b0;
        osc_en     = 1'b0;
        pll_en     = 1'b0;
        pins_hiz   = 1'b0;
        mode       = MODE_WAKE;
        case (state)
            ST_RUN: begin
                cpu_clk_en = tick && !pausing;
                per_clk_en = tick;
                tbt_clk_en = tick;
                osc_en     = 1'b1;
                pll_en     = !sel_main;
                mode       = mcm ? MODE_MAIN_RUN : MODE_PLL_RUN;
            end
            ST_SLEEP: begin
                per_clk_en = tick;
                tbt_clk_en = tick;
                osc_en     = 1'b1;
                pll_en     = !sel_main;
                mode       = mcm ? MODE_MAIN_SLP : MODE_PLL_SLEEP;
            end
            ST_WATCH: begin
                tbt_clk_en = ph;
                osc_en     = 1'b1;
                pins_hiz   = spl;
                mode       = MODE_WATCH;
            end
            ST_STOP: begin
                pins_hiz = spl;
                mode     = MODE_STOP;
            end
            ST_STBY: begin
                pins_hiz = spl;
                mode     = MODE_STBY;
            end
            default: begin
                osc_en = 1'b1;
                mode   = MODE_WAKE;
            end
        endcase
    end

    assign pll_src = !mcm;

    AST_SLEEP_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !stop_req && !irq_wake && !hw_stby) |=> !cpu_clk_en); // R5
    AST_STOP_KILLS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && !sleep_req && !irq_wake && !hw_stby) |=> (!osc_en && !pll_en)); // R7
    AST_PAUSE_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        pausing |-> !cpu_clk_en); // R11

endmodule

// File: tb/test_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module test_pwr_clk_ctrl;

    localparam int E0 = 2;
    localparam int E1 = 3;
    localparam int E2 = 4;
    localparam int E3 = 5;
    localparam int PU = 8;

    logic       clk = 1'b0;
    logic       rst_n, hw_stby, reg_wr, reg_addr, irq_wake, cpu_access, pll_lock;
    logic [7:0] reg_wdata, reg_rdata;
    logic       osc_en, pll_en, pll_src, cpu_clk_en, per_clk_en, tbt_clk_en;
    logic       sys_rst_pulse, pins_hiz;
    logic [1:0] pll_mult;
    logic [2:0] mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwr_clk_ctrl #(
        .WAIT_EXP0(E0), .WAIT_EXP1(E1), .WAIT_EXP2(E2), .WAIT_EXP3(E3), .PAUSE_UNIT(PU)
    ) i_pwr_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_wake(irq_wake),
        .cpu_access(cpu_access), .pll_lock(pll_lock), .osc_en(osc_en), .pll_en(pll_en),
        .pll_mult(pll_mult), .pll_src(pll_src), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .tbt_clk_en(tbt_clk_en), .sys_rst_pulse(sys_rst_pulse),
        .pins_hiz(pins_hiz), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #0.5;
        v = int'(reg_rdata);
    endtask

    function automatic int wexp(input int c);
        case (c)
            0: return E0;
            1: return E1;
            2: return E2;
            default: return E3;
        endcase
    endfunction

    function automatic int plen(input int c);
        return (c == 0) ? 0 : (PU << (c - 1));
    endfunction

    task automatic count_wake(input string req, input int exp);
        int n = 0;
        while (mode == 3'd7 && n < 100000) begin
            n++;
            step();
        end
        chk(req, n, exp);
    endtask

    initial begin
        int v, prev, ones, n;
        bit per_ok;
        rst_n = 1'b0; hw_stby = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
        irq_wake = 1'b0; cpu_access = 1'b0; pll_lock = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk("R1 lpm reset", v, 'h10);
        rd(1'b1, v); chk("R1 cks reset", v, 'hFC);
        chk("R1 mode", int'(mode), 2);
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 pll_en", int'(pll_en), 0);
        chk("R1 swrst", int'(sys_rst_pulse), 0);
        step();

        // R3 main-run half-rate enables
        prev = int'(cpu_clk_en); ones = 0;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R3 toggle", int'(cpu_clk_en), prev ^ 1);
            chk("R3 per=cpu", int'(per_clk_en), int'(cpu_clk_en));
            chk("R3 tbt=cpu", int'(tbt_clk_en), int'(cpu_clk_en));
            prev = int'(cpu_clk_en);
            ones += prev;
        end
        chk("R3 duty", ones, 4);
        chk("R3 pll off", int'(pll_en), 0);

        // R2 / R13 sweep of clock-select fields
        for (int w = 0; w < 4; w++) begin
            for (int m = 0; m < 4; m++) begin
                wr(1'b1, 8'((w << 4) | 4 | m));
                rd(1'b1, v);
                chk("R2 cks readback", v, 'hC0 | (w << 4) | 'h08 | 'h04 | m);
                chk("R13 mult", int'(pll_mult), m);
            end
        end

        // R2 / R12 mode-control register
        wr(1'b0, 8'h3E);
        rd(1'b0, v); chk("R2 lpm readback", v, 'h36);
        chk("R12 no pulse on 1", int'(sys_rst_pulse), 0);
        wr(1'b0, 8'h00);
        chk("R12 pulse", int'(sys_rst_pulse), 1);
        step();
        chk("R12 pulse ends", int'(sys_rst_pulse), 0);
        rd(1'b0, v); chk("R2 lpm cleared", v, 'h10);

        // R4 switch to PLL
        wr(1'b1, 8'h12);
        chk("R4 pll_en", int'(pll_en), 1);
        chk("R4 still main", int'(mode), 2);
        repeat (3) step();
        chk("R4 waits lock", int'(mode), 2);
        rd(1'b1, v); chk("R4 status main", (v >> 6) & 1, 1);
        pll_lock = 1'b1;
        step();
        chk("R4 pll run", int'(mode), 0);
        chk("R4 pll_src", int'(pll_src), 1);
        rd(1'b1, v); chk("R4 status pll", v, 'h9A);
        for (int i = 0; i < 4; i++) begin
            chk("R4 full rate", int'(cpu_clk_en), 1);
            step();
        end

        // R11 throttle sweep
        for (int c = 0; c < 4; c++) begin
            wr(1'b0, 8'(8'h10 | (c << 1)));
            cpu_access = 1'b1;
            step();
            cpu_access = 1'b0;
            n = 0; per_ok = 1'b1;
            while (cpu_clk_en == 1'b0 && n < 100) begin
                if (per_clk_en != 1'b1) per_ok = 1'b0;
                if (n == 2) cpu_access = 1'b1;   // access during pause is ignored
                else cpu_access = 1'b0;
                n++;
                step();
            end
            cpu_access = 1'b0;
            chk("R11 pause length", n, plen(c));
            chk("R11 per unaffected", int'(per_ok), 1);
            repeat (2) step();
            chk("R11 no extra pause", int'(cpu_clk_en), 1);
        end
        wr(1'b0, 8'h10);

        // R5 sleep, R9 wake
        wr(1'b0, 8'h50);
        chk("R5 mode", int'(mode), 1);
        chk("R5 cpu off", int'(cpu_clk_en), 0);
        chk("R5 per on", int'(per_clk_en), 1);
        chk("R5 tbt on", int'(tbt_clk_en), 1);
        chk("R5 osc on", int'(osc_en), 1);
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk("R9 sleep exit", int'(mode), 0);
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk("R9 irq in run", int'(mode), 0);
        irq_wake = 1'b1; wr(1'b0, 8'h50); irq_wake = 1'b0;
        chk("R9 sleep collision", int'(mode), 0);
        irq_wake = 1'b1; wr(1'b0, 8'h90); irq_wake = 1'b0;
        chk("R9 stop collision", int'(mode), 0);

        // R6 watch, R14 pin hold
        wr(1'b0, 8'h30);
        chk("R14 hiz off in run", int'(pins_hiz), 0);
        wr(1'b0, 8'hF0);
        chk("R6 mode", int'(mode), 4);
        chk("R14 hiz in watch", int'(pins_hiz), 1);
        chk("R6 osc", int'(osc_en), 1);
        chk("R6 pll", int'(pll_en), 0);
        ones = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R6 cpu off", int'(cpu_clk_en), 0);
            chk("R6 per off", int'(per_clk_en), 0);
            ones += int'(tbt_clk_en);
            step();
        end
        chk("R6 tbt half rate", ones, 2);
        rd(1'b1, v); chk("R4 status forced main", (v >> 6) & 1, 1);
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk("R9 watch exit", int'(mode), 2);
        chk("R14 hiz off", int'(pins_hiz), 0);
        step();
        chk("R4 relock", int'(mode), 0);

        // R7 / R8 stop and wake sweep
        for (int w = 0; w < 4; w++) begin
            wr(1'b1, 8'(w << 4));
            wr(1'b0, 8'hB0);
            chk("R7 mode", int'(mode), 5);
            chk("R7 osc", int'(osc_en), 0);
            chk("R7 pll", int'(pll_en), 0);
            chk("R7 clocks", int'({cpu_clk_en, per_clk_en, tbt_clk_en}), 0);
            chk("R14 hiz stop", int'(pins_hiz), 1);
            pll_lock = 1'b0;
            step();
            chk("R7 stays", int'(mode), 5);
            irq_wake = 1'b1; step(); irq_wake = 1'b0;
            chk("R8 osc on", int'(osc_en), 1);
            count_wake("R8 wait length", 1 << wexp(w));
            chk("R8 run after", int'(mode), 2);
            pll_lock = 1'b1;
            step();
            chk("R4 relock after stop", int'(mode), 0);
        end

        // R10 standby from PLL run and from main sleep
        hw_stby = 1'b1; step();
        chk("R10 mode", int'(mode), 6);
        chk("R10 osc", int'(osc_en), 0);
        chk("R10 pll", int'(pll_en), 0);
        chk("R10 clocks", int'({cpu_clk_en, per_clk_en, tbt_clk_en}), 0);
        pll_lock = 1'b0;
        repeat (2) step();
        chk("R10 holds", int'(mode), 6);
        hw_stby = 1'b0; step();
        count_wake("R10 wait length", 1 << E3);
        chk("R10 run after", int'(mode), 2);
        wr(1'b0, 8'h50);
        chk("R5 main sleep", int'(mode), 3);
        hw_stby = 1'b1; step();
        chk("R10 from sleep", int'(mode), 6);
        hw_stby = 1'b0; step();
        count_wake("R10 wait again", 1 << E3);
        chk("R10 run again", int'(mode), 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule